// File: doc/BRIEF.md
# Bit-Pair Encoded Atomic Register

This block is a single 32-bit control register that stores sixteen independent boolean flags. Every flag is given a two-bit field in the bus word. A write carries one command per field, so a single bus transfer can raise some flags, drop others and keep the rest untouched. Software never has to read the register first, and two drivers that share the register cannot overwrite each other's flags through a stale read-modify-write.

A read returns a redundant code for each flag: `01` for a cleared flag and `10` for a raised one. A decoded copy of the sixteen flags is also driven in parallel to the surrounding hardware. The register responds only at its own offset on a simple synchronous bus. The write takes effect on the clock edge that samples the write strobe. Reads are combinational from the address. The bus carries no streaming data, so there is no valid/ready handshake and the pins stay plain.

Top module: `pair_atomic_reg`

## Requirements
- R1: After reset every flag is 0, `flags_o` is 0 and a read at the register offset returns 0x55555555.
- R2: Flag k occupies bus bits [2k+1:2k]; on a read that field shows `01` when the flag is 0 and `10` when it is 1.
- R3: A write whose field k holds `10` sets flag k to 1.
- R4: A write whose field k holds `01` clears flag k to 0.
- R5: A write whose field k holds `11` leaves flag k unchanged.
- R6: A write whose field k holds `00` leaves flag k unchanged.
- R7: All sixteen fields of one write act on the same clock edge, independently of each other. Starting from flags 0 and 7 set, the write 0xFFFFF7EF yields a read of 0x55559566.
- R8: The register is decoded at offset 0x20. A write to any other offset changes no flag, and a read at any other offset returns 0.
- R9: With `bus_we` low, no flag changes, whatever `bus_wdata` holds.
- R10: `flags_o` bit k always equals the stored value of flag k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write word, one two-bit command per flag |
| bus_rdata | output | 32 | Read word, one two-bit code per flag, 0 when the offset does not match |
| flags_o | output | 16 | Decoded flag values for hardware use |

## Verification
A flag that is stored wrongly shows up on `flags_o` right after the edge of the faulty write. It also shows up as a wrong two-bit code on the next read at 0x20. A corrupted code path shows up differently: the read field turns into `00` or `11`, or it disagrees with the matching `flags_o` bit. The bench compares both views after every bus cycle. A fault therefore surfaces within one cycle of the write that caused it.

// File: rtl/pair_reg_pkg.sv
package pair_reg_pkg;
  // Two-bit write command carried by each field
  typedef enum logic [1:0] {
    CMD_KEEP_LO = 2'b00,
    CMD_CLEAR   = 2'b01,
    CMD_SET     = 2'b10,
    CMD_KEEP_HI = 2'b11
  } pair_cmd_e;

  // Read code for one stored flag: 0 -> 01, 1 -> 10
  function automatic logic [1:0] pair_code(input logic v);
    return v ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/pair_reg_decode.sv
module pair_reg_decode #(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic              wr_stb_o
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_OFFSET);

  always_comb begin
    hit_o    = (addr_i == MATCH);
    wr_stb_o = hit_o && we_i;
  end
endmodule

// File: rtl/pair_cell.sv
module pair_cell
  import pair_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb_i,
  input  logic [1:0] cmd_i,
  output logic       value_o
);
  logic nxt;

  always_comb begin
    nxt = value_o;
    if (wr_stb_i) begin
      unique case (pair_cmd_e'(cmd_i))
        CMD_SET:   nxt = 1'b1;
        CMD_CLEAR: nxt = 1'b0;
        default:   nxt = value_o;   // both keep codes
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_o <= 1'b0;
    else        value_o <= nxt;
  end
endmodule

// File: rtl/pair_reg_readback.sv
module pair_reg_readback
  import pair_reg_pkg::*;
#(
  parameter int NUM_VALS = 16
) (
  input  logic                  hit_i,
  input  logic [NUM_VALS-1:0]   flags_i,
  output logic [2*NUM_VALS-1:0] rdata_o
);
  logic [2*NUM_VALS-1:0] coded;

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_code
    assign coded[2*k+1 -: 2] = pair_code(flags_i[k]);
  end

  assign rdata_o = hit_i ? coded : '0;
endmodule

// File: rtl/pair_atomic_reg.sv
module pair_atomic_reg #(
  parameter int         NUM_VALS   = 16,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] REG_OFFSET = 8'h20,
  localparam int        DATA_W     = 2 * NUM_VALS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_VALS-1:0] flags_o
);
  logic hit;
  logic wr_stb;

  pair_reg_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .addr_i   (bus_addr),
    .we_i     (bus_we),
    .hit_o    (hit),
    .wr_stb_o (wr_stb)
  );

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_cell
    pair_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb_i (wr_stb),
      .cmd_i    (bus_wdata[2*k+1 -: 2]),
      .value_o  (flags_o[k])
    );
  end

  pair_reg_readback #(.NUM_VALS(NUM_VALS)) u_rd (
    .hit_i   (hit),
    .flags_i (flags_o),
    .rdata_o (bus_rdata)
  );
endmodule

// File: rtl/pair_atomic_reg_checker.sv
module pair_atomic_reg_checker #(
  parameter int         NUM_VALS   = 16,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] REG_OFFSET = 8'h20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [2*NUM_VALS-1:0] bus_wdata,
  input logic [2*NUM_VALS-1:0] bus_rdata,
  input logic [NUM_VALS-1:0]   flags_o
);
  logic at_reg;
  logic wr;
  assign at_reg = (bus_addr == ADDR_W'(REG_OFFSET));
  assign wr     = at_reg && bus_we;

  // R1: flags stay clear while reset is held
  always @(posedge clk)
    if (!rst_n) assert (flags_o == '0) else $error("p_reset_clear_r1");

  // R8: reads away from the offset are zero
  p_miss_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !at_reg |-> bus_rdata == '0);

  // R9 and R8: no matching write, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(flags_o));

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_prop
    // R2 and R10: read code agrees with the decoded output
    p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      at_reg |-> (bus_rdata[2*k+1 -: 2] == (flags_o[k] ? 2'b10 : 2'b01)));
    // R3
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_wdata[2*k+1 -: 2] == 2'b10) |=> flags_o[k]);
    // R4
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_wdata[2*k+1 -: 2] == 2'b01) |=> !flags_o[k]);
    // R5 and R6
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (bus_wdata[2*k+1 -: 2] == 2'b11 || bus_wdata[2*k+1 -: 2] == 2'b00))
      |=> $stable(flags_o[k]));
  end
endmodule

bind pair_atomic_reg pair_atomic_reg_checker #(
  .NUM_VALS(NUM_VALS), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags_o(flags_o)
);

// File: tb/pair_atomic_reg_test.sv
module pair_atomic_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] flags_o;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [15:0] model = '0;

  always #2 clk = ~clk;   // 250 MHz

  pair_atomic_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags_o(flags_o)
  );

  function automatic logic [15:0] apply_cmd(input logic [15:0] old, input logic [31:0] w);
    logic [15:0] r = old;
    for (int k = 0; k < 16; k++) begin
      if (w[2*k+1 -: 2] == 2'b10) r[k] = 1'b1;
      else if (w[2*k+1 -: 2] == 2'b01) r[k] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] encode(input logic [15:0] f);
    logic [31:0] r;
    for (int k = 0; k < 16; k++) r[2*k+1 -: 2] = f[k] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // one bus cycle, inputs driven at negedge, model updated when it commits
  task automatic bus_cycle(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (we && a == 8'h20) model = apply_cmd(model, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // observe both views at the register offset
  task automatic observe(input string req);
    bus_addr = 8'h20;
    #1;
    check32(req, bus_rdata, encode(model));
    check32(req, {16'h0, flags_o}, {16'h0, model});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    check32("R1", bus_rdata, 32'h0);          // addr 0 during reset -> miss
    @(negedge clk); rst_n = 1'b1;
    observe("R1");
    check32("R1", bus_rdata, 32'h5555_5555);

    // R3: set every flag
    bus_cycle(1'b1, 8'h20, 32'hAAAA_AAAA);
    observe("R3");
    check32("R3", bus_rdata, 32'hAAAA_AAAA);
    // R6: all 00 keeps
    bus_cycle(1'b1, 8'h20, 32'h0000_0000);
    observe("R6");
    // R4: clear every flag
    bus_cycle(1'b1, 8'h20, 32'h5555_5555);
    observe("R4");
    check32("R4", {16'h0, flags_o}, 32'h0);
    // R7 worked case: set 0 and 7 then the mixed word
    bus_cycle(1'b1, 8'h20, 32'hFFFF_BFFE);
    observe("R7");
    bus_cycle(1'b1, 8'h20, 32'hFFFF_F7EF);
    observe("R7");
    check32("R7", bus_rdata, 32'h5555_9566);
    // R5: all 11 keeps
    bus_cycle(1'b1, 8'h20, 32'hFFFF_FFFF);
    observe("R5");
    check32("R5", bus_rdata, 32'h5555_9566);
    // R8: foreign offset write ignored, foreign read returns zero
    bus_cycle(1'b1, 8'h24, 32'hAAAA_AAAA);
    bus_addr = 8'h24; #1;
    check32("R8", bus_rdata, 32'h0);
    observe("R8");
    // R9: strobe low at the offset
    bus_cycle(1'b0, 8'h20, 32'hAAAA_AAAA);
    observe("R9");
    // R7: set top and clear bottom in one edge
    bus_cycle(1'b1, 8'h20, 32'h9FFF_FFFD);
    observe("R7");

    // random mix, R2 R3 R4 R5 R6 R10 checked against the model
    for (int i = 0; i < 400; i++) begin
      w = $urandom;
      bus_cycle(($urandom % 4) != 0, (($urandom % 5) == 0) ? 8'h24 : 8'h20, w);
      observe("R2 R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule